// File: doc/BRIEF.md
# Parallel Host Bus Slave Front End

This block sits between a parallel CPU bus running in synchronous mode and a 32-bit internal memory and register space. Each host word is turned into a request on a simple request/acknowledge port. The bus can be set up in three ways through static inputs. `cfg_mux` chooses a shared address/data bus or a separate address bus. `cfg_wide` chooses a 32-bit or 16-bit data path. `cfg_pol` selects the polarity used to decode direction and half-word select.

A transfer opens when the active-low strobe is seen while the block is idle. After that, the host moves one beat (one word, or one 16-bit half) on every clock edge at which `hb_ready` is high. A beat taken with the strobe high is sequential and uses the previous word address plus one. A beat taken with the strobe still low is random and loads a fresh address. The active-low last-word input, sampled on a beat, closes the transfer. In 16-bit mode the first half of a write waits in a staging register, and one 32-bit write is issued when the second half arrives. A 16-bit read fetches the word once and returns both halves from it.

The controller has three states.
- IDLE: waiting for a strobe. `hb_ready` is high.
- ACCESS: an internal request is outstanding. `hb_ready` is low.
- NEXT: inside a burst. Every clock is a beat.

Transitions:
- IDLE->ACCESS and NEXT->ACCESS: on a beat that needs the internal port.
- IDLE->NEXT and NEXT->NEXT: on a beat that needs no access and is not the last.
- IDLE->IDLE and NEXT->IDLE: on a last beat that needs no access.
- ACCESS->NEXT: on acknowledge when the last word has not been seen.
- ACCESS->IDLE: on acknowledge after the last word.

Top module: `hostbus_slave`

## Requirements
- R1: After reset `hb_ready` is 1, `m_req` is 0 and `hb_rdata` is 0.
- R2: Direction decode: with `cfg_wide`=1 and `cfg_pol`=1, `hb_dir`=1 means write. In every other configuration `hb_dir`=0 means write. The direction is taken on the opening beat and holds for the whole transfer.
- R3: A single-word access is a one-cycle strobe with `hb_last_n` low. It produces exactly one internal access (one per half-word pair in 16-bit mode). Each acknowledge ends its request on the next cycle.
- R4: In a sequential burst the word address advances by one after each completed 32-bit word. In 16-bit mode that is after each pair of halves. Address pins and latched addresses are ignored on those beats.
- R5: A beat taken with the strobe still low (random burst) loads its own address and memory/register select.
- R6: With `cfg_mux`=1, a cycle with `hb_ale` high latches `hb_wdata[15:0]` as the address, together with `hb_space` and `hb_half`, and no beat is taken in that cycle. With `cfg_mux`=0 the address comes from `hb_addr` and `hb_ale` has no effect.
- R7: In 16-bit mode the decoded half is upper (bits 31:16) when `hb_half` equals `cfg_pol`, and lower otherwise. In 32-bit mode `hb_half` is ignored.
- R8: In 16-bit write mode the first half of a pair is staged and causes no access. The second half issues one 32-bit write that combines both halves in their selected positions.
- R9: In 16-bit read mode the first half of a pair issues one 32-bit read. Both halves are returned on `hb_rdata[15:0]` with bits 31:16 at zero, and the second half causes no access.
- R10: `hb_ready` is low whenever `m_req` is high. `m_addr`, `m_we` and `m_wdata` stay stable from the start of a request until its acknowledge.
- R11: `m_mask` carries the `hb_wen` value from the beat that completed the word.
- R12: After the last beat the block returns to idle. Cycles with the strobe high then cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mux | input | 1 | Static: 1 = shared address/data bus |
| cfg_wide | input | 1 | Static: 1 = 32-bit data path, 0 = 16-bit |
| cfg_pol | input | 1 | Static polarity select |
| hb_strobe_n | input | 1 | Active-low data strobe |
| hb_dir | input | 1 | Direction, decoded per R2 |
| hb_ale | input | 1 | Address latch enable (tie high when not multiplexed) |
| hb_last_n | input | 1 | Active-low last-word marker |
| hb_half | input | 1 | Half-word select, decoded per R7 |
| hb_space | input | 1 | Memory/register space select |
| hb_addr | input | ADDR_W | Separate address bus |
| hb_wen | input | 2 | Word enables, passed to the mask |
| hb_wdata | input | DATA_W | Host write data (address in multiplexed latch cycles) |
| hb_rdata | output | DATA_W | Host read data |
| hb_ready | output | 1 | High when a beat can be taken |
| m_req | output | 1 | Internal access request |
| m_we | output | 1 | Internal write when 1 |
| m_space | output | 1 | Internal memory/register select |
| m_addr | output | ADDR_W | Internal word address |
| m_wdata | output | DATA_W | Internal write word |
| m_mask | output | 2 | Internal write enable mask |
| m_ack | input | 1 | Internal access acknowledge |
| m_rdata | input | DATA_W | Internal read word |

## Verification
The bench runs all eight static configurations. In each one it does single writes and reads, three-word sequential bursts and two-word random bursts, against a memory model with wait states, and then idles.

Several faults show up directly as wrong memory contents or readback:
- A swapped direction decode turns writes into reads, so the stored words never change.
- A reversed half-word decode swaps the two halves of every 16-bit word.
- A sequential beat that reloads from the pins stores data at the garbage address the bench drives there.
- A random beat that increments instead of reloading writes to the wrong word.

Access counters catch two further faults: a 16-bit write that issues a partial access per half, and a 16-bit read that fetches twice per pair. In multiplexed mode the pins carry a wrong address, so a design that ignores the latch writes to the wrong word.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_NEXT   = 2'd2
    } hbs_state_e;

    // Direction decode: polarity flips only for the wide path with pol set.
    function automatic logic dir_is_write(input logic wide, input logic pol, input logic dir);
        return (wide && pol) ? dir : !dir;
    endfunction

    // Half-word decode: upper when the select equals the polarity input.
    function automatic logic half_is_upper(input logic pol, input logic half);
        return pol ? half : !half;
    endfunction

endpackage

// File: rtl/hbs_addr_unit.sv
module hbs_addr_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mux,
    input  logic              cfg_pol,
    input  logic              ale,
    input  logic [ADDR_W-1:0] bus_lo,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic              pin_space,
    input  logic              pin_half,
    input  logic              beat,
    input  logic              reload,
    input  logic              word_done,
    output logic [ADDR_W-1:0] word_addr,
    output logic              space_q,
    output logic              upper_now
);
    import hbs_pkg::*;

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_space;
    logic              lat_half;
    logic              adv_q;
    logic [ADDR_W-1:0] src_addr;
    logic              src_space;
    logic              src_half;
    logic [ADDR_W-1:0] next_addr;

    // Multiplexed address phase capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_space <= 1'b0;
            lat_half  <= 1'b0;
        end else if (cfg_mux && ale) begin
            lat_addr  <= bus_lo;
            lat_space <= pin_space;
            lat_half  <= pin_half;
        end
    end

    always_comb begin
        src_addr  = cfg_mux ? lat_addr  : pin_addr;
        src_space = cfg_mux ? lat_space : pin_space;
        src_half  = cfg_mux ? lat_half  : pin_half;
        upper_now = half_is_upper(cfg_pol, src_half);
        if (reload) begin
            next_addr = src_addr;
        end else if (adv_q) begin
            next_addr = word_addr + ADDR_W'(1);
        end else begin
            next_addr = word_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr <= '0;
            space_q   <= 1'b0;
            adv_q     <= 1'b0;
        end else if (beat) begin
            word_addr <= next_addr;
            adv_q     <= word_done;
            if (reload) begin
                space_q <= src_space;
            end
        end
    end

endmodule

// File: rtl/hbs_half_unit.sv
module hbs_half_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              beat,
    input  logic              wr_now,
    input  logic              is_second,
    input  logic              upper_now,
    input  logic              need_access,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] word_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] stage;
    logic [DATA_W-1:0] rbuf;
    logic              upper_q;

    always_comb begin
        if (cfg_wide) begin
            word_wdata = bus_wdata;
        end else if (upper_now) begin
            word_wdata = {bus_wdata[HALF_W-1:0], stage};
        end else begin
            word_wdata = {stage, bus_wdata[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage   <= '0;
            upper_q <= 1'b0;
        end else if (beat) begin
            upper_q <= upper_now;
            if (!cfg_wide && !is_second) begin
                stage <= bus_wdata[HALF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbuf       <= '0;
            host_rdata <= '0;
        end else if (rd_ack) begin
            rbuf <= rd_word;
            if (cfg_wide) begin
                host_rdata <= rd_word;
            end else begin
                host_rdata <= {{HALF_W{1'b0}},
                               upper_q ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0]};
            end
        end else if (beat && !wr_now && !cfg_wide && !need_access) begin
            host_rdata <= {{HALF_W{1'b0}},
                           upper_now ? rbuf[DATA_W-1:HALF_W] : rbuf[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_mux,
    input  logic cfg_wide,
    input  logic cfg_pol,
    input  logic strobe_n,
    input  logic dir,
    input  logic ale,
    input  logic last_n,
    input  logic ack,
    output logic beat,
    output logic reload,
    output logic wr_now,
    output logic wr_q,
    output logic is_second,
    output logic need_access,
    output logic word_done,
    output logic ready,
    output logic req,
    output logic idle
);
    import hbs_pkg::*;

    hbs_state_e state, state_nx;
    logic       last_q;
    logic       hphase;
    logic       first;
    logic       addr_phase;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Beat-level bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            wr_q   <= 1'b0;
            hphase <= 1'b0;
        end else if (beat) begin
            last_q <= !last_n;
            wr_q   <= wr_now;
            hphase <= cfg_wide ? 1'b0 : !is_second;
        end
    end

    // Beat qualification and next state
    always_comb begin
        addr_phase = cfg_mux && ale;
        first      = (state == ST_IDLE);
        beat       = 1'b0;
        reload     = 1'b0;
        state_nx   = state;
        unique case (state)
            ST_IDLE: begin
                beat   = !strobe_n && !addr_phase;
                reload = 1'b1;
            end
            ST_NEXT: begin
                beat   = !addr_phase;
                reload = !strobe_n;
            end
            ST_ACCESS: begin
                beat   = 1'b0;
                reload = 1'b0;
            end
            default: begin
                beat   = 1'b0;
                reload = 1'b0;
            end
        endcase
        wr_now      = first ? dir_is_write(cfg_wide, cfg_pol, dir) : wr_q;
        is_second   = !cfg_wide && !first && hphase;
        need_access = cfg_wide || (wr_now ? is_second : !is_second);
        word_done   = cfg_wide || is_second;
        unique case (state)
            ST_IDLE, ST_NEXT: begin
                if (beat) begin
                    if (need_access) begin
                        state_nx = ST_ACCESS;
                    end else if (!last_n) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_NEXT;
                    end
                end
            end
            ST_ACCESS: begin
                if (ack) begin
                    state_nx = last_q ? ST_IDLE : ST_NEXT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready = 1'b1;
        req   = 1'b0;
        idle  = 1'b0;
        unique case (state)
            ST_IDLE:   idle  = 1'b1;
            ST_ACCESS: begin
                ready = 1'b0;
                req   = 1'b1;
            end
            ST_NEXT:   ready = 1'b1;
            default:   ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mux,
    input  logic              cfg_wide,
    input  logic              cfg_pol,
    input  logic              hb_strobe_n,
    input  logic              hb_dir,
    input  logic              hb_ale,
    input  logic              hb_last_n,
    input  logic              hb_half,
    input  logic              hb_space,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [1:0]        hb_wen,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              hb_ready,
    output logic              m_req,
    output logic              m_we,
    output logic              m_space,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [1:0]        m_mask,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_rdata
);
    logic              beat;
    logic              reload;
    logic              wr_now;
    logic              wr_q;
    logic              is_second;
    logic              need_access;
    logic              word_done;
    logic              ctrl_idle;
    logic              upper_now;
    logic [DATA_W-1:0] word_wdata;

    hbs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mux     (cfg_mux),
        .cfg_wide    (cfg_wide),
        .cfg_pol     (cfg_pol),
        .strobe_n    (hb_strobe_n),
        .dir         (hb_dir),
        .ale         (hb_ale),
        .last_n      (hb_last_n),
        .ack         (m_ack),
        .beat        (beat),
        .reload      (reload),
        .wr_now      (wr_now),
        .wr_q        (wr_q),
        .is_second   (is_second),
        .need_access (need_access),
        .word_done   (word_done),
        .ready       (hb_ready),
        .req         (m_req),
        .idle        (ctrl_idle)
    );

    hbs_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mux   (cfg_mux),
        .cfg_pol   (cfg_pol),
        .ale       (hb_ale),
        .bus_lo    (hb_wdata[ADDR_W-1:0]),
        .pin_addr  (hb_addr),
        .pin_space (hb_space),
        .pin_half  (hb_half),
        .beat      (beat),
        .reload    (reload),
        .word_done (word_done),
        .word_addr (m_addr),
        .space_q   (m_space),
        .upper_now (upper_now)
    );

    hbs_half_unit #(.DATA_W(DATA_W)) u_half (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wide    (cfg_wide),
        .beat        (beat),
        .wr_now      (wr_now),
        .is_second   (is_second),
        .upper_now   (upper_now),
        .need_access (need_access),
        .bus_wdata   (hb_wdata),
        .rd_ack      (m_req && m_ack && !m_we),
        .rd_word     (m_rdata),
        .word_wdata  (word_wdata),
        .host_rdata  (hb_rdata)
    );

    assign m_we = wr_q;

    // Write word and mask are held from the issuing beat until the next one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wdata <= '0;
            m_mask  <= 2'b00;
        end else if (beat && need_access) begin
            m_wdata <= word_wdata;
            m_mask  <= hb_wen;
        end
    end

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mux,
    input logic              ale,
    input logic              strobe_n,
    input logic              idle,
    input logic              ready,
    input logic              req,
    input logic              ack,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
);
    // R10: host is stalled while an internal request is open
    a_r10_ready_low_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !ready);

    // R10: request fields hold until acknowledged
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata)));

    // R3: each acknowledge closes its request
    a_r3_one_access_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    // R12: an idle bus with strobe high starts nothing
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && strobe_n) |=> !req);

    // R6: an address-phase cycle never becomes a beat
    a_r6_ale_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_mux && ale) |=> !req);

endmodule

bind hostbus_slave hbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mux  (cfg_mux),
    .ale      (hb_ale),
    .strobe_n (hb_strobe_n),
    .idle     (ctrl_idle),
    .ready    (hb_ready),
    .req      (m_req),
    .ack      (m_ack),
    .we       (m_we),
    .addr     (m_addr),
    .wdata    (m_wdata)
);

// File: tb/hostbus_slave_test.sv
module hostbus_slave_test;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_mux, cfg_wide, cfg_pol;
    logic          hb_strobe_n, hb_dir, hb_ale, hb_last_n, hb_half, hb_space;
    logic [AW-1:0] hb_addr;
    logic [1:0]    hb_wen;
    logic [DW-1:0] hb_wdata;
    logic [DW-1:0] hb_rdata;
    logic          hb_ready;
    logic          m_req, m_we, m_space;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic [1:0]    m_mask;
    logic          m_ack;
    logic [DW-1:0] m_rdata;

    int checks = 0;
    int fails  = 0;
    int nwr = 0;
    int nrd = 0;
    int wc = 0;
    logic [1:0]  last_mask = 2'b00;
    logic [31:0] mem [0:127];

    always #2 clk = ~clk;

    hostbus_slave #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_wide(cfg_wide), .cfg_pol(cfg_pol),
        .hb_strobe_n(hb_strobe_n), .hb_dir(hb_dir), .hb_ale(hb_ale), .hb_last_n(hb_last_n),
        .hb_half(hb_half), .hb_space(hb_space), .hb_addr(hb_addr), .hb_wen(hb_wen),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ready(hb_ready), .m_req(m_req),
        .m_we(m_we), .m_space(m_space), .m_addr(m_addr), .m_wdata(m_wdata), .m_mask(m_mask),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    // Memory model: acknowledges after two wait cycles
    initial begin
        m_ack   = 1'b0;
        m_rdata = '0;
        for (int i = 0; i < 128; i++) mem[i] = 32'hDEAD_0000 | i;
        forever begin
            @(negedge clk);
            if (m_req && !m_ack) begin
                wc++;
                if (wc >= 2) begin
                    m_ack = 1'b1;
                    wc = 0;
                    if (m_we) begin
                        mem[{m_space, m_addr[5:0]}] = m_wdata;
                        nwr++;
                        last_mask = m_mask;
                    end else begin
                        m_rdata = mem[{m_space, m_addr[5:0]}];
                        nrd++;
                    end
                end
            end else begin
                m_ack = 1'b0;
                wc = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        hb_strobe_n = 1'b1;
        hb_last_n   = 1'b1;
    endtask

    // One beat; entered and left at a negedge with hb_ready high
    task automatic beat(input bit slow, input logic [15:0] a, input bit sp, input bit up,
                        input bit last, input logic [31:0] d, input bit wr, input logic [1:0] we);
        logic hv;
        hv = cfg_wide ? ~hb_half : (cfg_pol ? up : !up);
        if (cfg_mux) begin
            hb_ale      = 1'b1;
            hb_strobe_n = 1'b1;
            hb_wdata    = {16'h0, a};
            hb_space    = sp;
            hb_half     = hv;
            @(posedge clk);
            @(negedge clk);
            hb_ale      = 1'b0;
        end
        hb_strobe_n = !slow;
        hb_last_n   = !last;
        hb_dir      = (cfg_wide && cfg_pol) ? wr : !wr;
        hb_addr     = cfg_mux ? 16'h003E : a;
        hb_space    = sp;
        hb_half     = hv;
        hb_wdata    = d;
        hb_wen      = we;
        @(posedge clk);
        @(negedge clk);
        while (!hb_ready) @(negedge clk);
    endtask

    task automatic write_word(input bit sf, input bit sr, input logic [15:0] af,
                              input logic [15:0] ar, input bit sp, input bit last,
                              input logic [31:0] d, input logic [1:0] we);
        if (cfg_wide) begin
            beat(sf, af, sp, 1'b1, last, d, 1'b1, we);
        end else begin
            beat(sf, af, sp, 1'b1, 1'b0, {16'h0, d[31:16]}, 1'b1, we);
            beat(sr, ar, sp, 1'b0, last, {16'h0, d[15:0]}, 1'b1, we);
        end
    endtask

    task automatic read_word(input string tag, input bit sf, input logic [15:0] af,
                             input bit sp, input bit last, input logic [31:0] exp);
        if (cfg_wide) begin
            beat(sf, af, sp, 1'b0, last, 32'h0, 1'b0, 2'b11);
            chk(tag, hb_rdata, exp);
        end else begin
            beat(sf, af, sp, 1'b1, 1'b0, 32'h0, 1'b0, 2'b11);
            chk(tag, hb_rdata, {16'h0, exp[31:16]});
            beat(1'b0, 16'h0031, sp, 1'b0, last, 32'h0, 1'b0, 2'b11);
            chk(tag, hb_rdata, {16'h0, exp[15:0]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_mux = 1'b0; cfg_wide = 1'b1; cfg_pol = 1'b0;
        hb_ale = 1'b1; hb_dir = 1'b0; hb_half = 1'b0; hb_space = 1'b0;
        hb_addr = '0; hb_wen = 2'b11; hb_wdata = '0;
        go_idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(hb_ready), 32'd1);
        chk("R1 req", 32'(m_req), 32'd0);
        chk("R1 rdata", hb_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int c = 0; c < 8; c++) begin
            logic [15:0] base;
            logic        sp;
            logic [31:0] d0;
            logic [1:0]  we;
            int          w0, r0;
            cfg_mux  = c[0];
            cfg_wide = c[1];
            cfg_pol  = c[2];
            hb_ale   = !cfg_mux;
            base = 16'(c * 6 + 1);
            sp   = c[0] ^ c[1];
            d0   = 32'hA500_001F + 32'(c) * 32'h0001_0203;
            we   = 2'(c + 1);
            @(negedge clk);

            // R3/R8/R11: single word write
            w0 = nwr;
            write_word(1'b1, 1'b0, base, base, sp, 1'b1, d0, we);
            go_idle();
            chk("R3 single write count", 32'(nwr - w0), 32'd1);
            chk("R8 R2 stored word", mem[{sp, base[5:0]}], d0);
            chk("R11 mask", 32'(last_mask), 32'(we));

            // R9/R7/R2: single word read
            r0 = nrd;
            read_word("R9 R7 single read", 1'b1, base, sp, 1'b1, d0);
            go_idle();
            chk("R9 single read count", 32'(nrd - r0), 32'd1);

            // R4: sequential write burst of three words, pins carry garbage
            w0 = nwr;
            for (int k = 0; k < 3; k++) begin
                write_word(k == 0, 1'b0, (k == 0) ? base : 16'h0033, 16'h0034, sp,
                           k == 2, d0 ^ (32'h1111_0000 * (k + 1)), 2'b11);
            end
            go_idle();
            chk("R4 burst write count", 32'(nwr - w0), 32'd3);
            for (int k = 0; k < 3; k++)
                chk("R4 burst word", mem[{sp, 6'(base[5:0] + k)}], d0 ^ (32'h1111_0000 * (k + 1)));

            // R4/R9: sequential read burst
            r0 = nrd;
            for (int k = 0; k < 3; k++) begin
                read_word("R4 burst read", k == 0, (k == 0) ? base : 16'h0035, sp, k == 2,
                          d0 ^ (32'h1111_0000 * (k + 1)));
            end
            go_idle();
            chk("R9 burst read count", 32'(nrd - r0), 32'd3);

            // R5: random write burst, strobe held low, own address per word
            write_word(1'b1, 1'b1, base + 16'd10, base + 16'd10, !sp, 1'b0, ~d0, 2'b11);
            write_word(1'b1, 1'b1, base + 16'd20, base + 16'd20, sp, 1'b1, d0 + 32'd7, 2'b11);
            go_idle();
            chk("R5 random word 0", mem[{!sp, 6'(base[5:0] + 10)}], ~d0);
            chk("R5 random word 1", mem[{sp, 6'(base[5:0] + 20)}], d0 + 32'd7);

            // R12: idle with strobe high produces no access
            w0 = nwr;
            r0 = nrd;
            repeat (6) @(negedge clk);
            chk("R12 idle no access", 32'((nwr - w0) + (nrd - r0)), 32'd0);
            chk("R12 ready idle", 32'(hb_ready), 32'd1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule